// File: doc/BRIEF.md
# Barrel-Shifter Receive Word Aligner

This block recovers 20-bit word boundaries from a deserialized 8b/10b receive stream. Each word holds two 10-bit characters, and the deserializer may place the word boundary at any bit. The aligner keeps the previous word and joins it with the current word into a 40-bit span. A barrel shifter takes a 20-bit window from that span at a bit offset. A small search machine looks for a comma in the low character of the window. When no comma shows up for a whole timeout, the offset moves forward by one bit. When commas keep arriving, the block declares lock.

Once locked, the block watches for words that hold a character with an impossible ones count. A long enough run of such words drops lock, and the search starts again from the offset in use. The shift offset and the search state are each held in three copies and read through a majority vote, so a single upset in one copy has no effect. The receive path feeds the registered window to the 8b/10b decoder, and the lock flag gates the link start-up logic.

Top module: `rx_word_aligner`

## Requirements
- R1: Bit 0 of every input word is the earliest received bit. The window at offset k is bits k to k+19 of the 40-bit span {current word, previous word}. The output word is that window, registered once, so at offset 0 the output equals the input word from two clock edges earlier.
- R2: A comma is a low window character (window bits 9:0) equal to 10'h17C or 10'h283. These are the two disparity forms of K28.5 with bit 0 received first.
- R3: Before lock, the offset starts at 0 after reset. It advances by exactly one after 256 consecutive clock edges with no comma, wraps from 19 to 0, and never changes while locked.
- R4: Lock is declared on the 4th consecutive clock edge whose window holds a comma. A window without a comma restarts that count.
- R5: The lock flag rises in the cycle after the edge that completes R4. Starting from reset with offset k needed, that is after edge 5 for k = 0 and after edge 256k + 4 otherwise. Edge 1 is the first edge with reset released.
- R6: While locked, a window is invalid when either 10-bit character has a ones count outside 4 to 6. Lock drops after 8 consecutive invalid windows, and any valid window restarts that count.
- R7: After lock is lost, the search resumes at the offset in use, so a comma stream that is still aligned locks again after 4 more comma windows.
- R8: While reset is asserted, the lock flag and the output word are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 20 | Deserialized word, bit 0 received first |
| word_out | output | 20 | Aligned word, registered |
| locked | output | 1 | High while alignment is locked |

## Verification
The output word is due one edge after the window is formed. When locked with slip s, it equals transmitted word e-2 after edge e for s = 0, and word e-1 for other slips. The lock flag is checked exactly on the edge before and on the edge of the lock cycles given in R5. The loss flag is checked on the 7th and the 8th invalid window. The bench counts edges from reset release and samples on falling edges, so each comparison reads the state left by a known edge.

// File: rtl/rx_word_aligner.sv
module rx_word_aligner #(
  parameter int W         = 20,
  parameter int CW        = 10,
  parameter int TIMEOUT   = 256,
  parameter int LOCK_HITS = 4,
  parameter int LOSS_ERRS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_word,
  output logic [W-1:0] word_out,
  output logic         locked
);
  localparam int OW  = $clog2(W);
  localparam int TW  = $clog2(TIMEOUT);
  localparam int HW  = $clog2(LOCK_HITS + 1);
  localparam int EW  = $clog2(LOSS_ERRS + 1);
  localparam int NCH = W / CW;
  localparam logic [CW-1:0] COMMA_N = CW'(10'h17C);
  localparam logic [CW-1:0] COMMA_P = CW'(10'h283);

  logic [W-1:0]   prev_q;
  logic [2*W-1:0] span;
  logic [W-1:0]   win;
  logic [OW-1:0]  off_r [3];
  logic           st_r  [3];
  logic [OW-1:0]  off_v, off_n;
  logic           st_v, st_n;
  logic [TW-1:0]  timer, timer_n;
  logic [HW-1:0]  hits, hits_n;
  logic [EW-1:0]  errs, errs_n;
  logic [NCH-1:0] ch_ok;
  logic           comma, bad;

  assign off_v = (off_r[0] & off_r[1]) | (off_r[0] & off_r[2]) | (off_r[1] & off_r[2]);
  assign st_v  = (st_r[0] & st_r[1]) | (st_r[0] & st_r[2]) | (st_r[1] & st_r[2]);

  assign span  = {rx_word, prev_q};
  assign win   = span[off_v +: W];
  assign comma = (win[CW-1:0] == COMMA_N) || (win[CW-1:0] == COMMA_P);

  for (genvar c = 0; c < NCH; c++) begin : g_char
    assign ch_ok[c] = ($countones(win[c*CW +: CW]) >= CW/2 - 1) &&
                      ($countones(win[c*CW +: CW]) <= CW/2 + 1);
  end
  assign bad    = ~&ch_ok;
  assign locked = st_v;

  always_comb begin
    st_n    = st_v;
    off_n   = off_v;
    timer_n = '0;
    hits_n  = '0;
    errs_n  = '0;
    if (!st_v) begin
      if (comma) begin
        if (hits == HW'(LOCK_HITS - 1)) st_n = 1'b1;
        else                            hits_n = hits + 1'b1;
      end else if (timer == TW'(TIMEOUT - 1)) begin
        off_n = (off_v == OW'(W - 1)) ? '0 : off_v + 1'b1;
      end else begin
        timer_n = timer + 1'b1;
      end
    end else if (bad) begin
      if (errs == EW'(LOSS_ERRS - 1)) st_n = 1'b0;
      else                            errs_n = errs + 1'b1;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_r[i] <= '0;
        st_r[i]  <= 1'b0;
      end else begin
        off_r[i] <= off_n;
        st_r[i]  <= st_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      word_out <= '0;
      timer    <= '0;
      hits     <= '0;
      errs     <= '0;
    end else begin
      prev_q   <= rx_word;
      word_out <= win;
      timer    <= timer_n;
      hits     <= hits_n;
      errs     <= errs_n;
    end
  end

  assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    off_v < OW'(W));
  assert_offset_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_v) |-> (off_v == (($past(off_v) == OW'(W - 1)) ? '0 : $past(off_v) + 1'b1)));
  assert_offset_hold_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(off_v));
  assert_lock_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(comma));
  assert_lock_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bad));
endmodule

// File: tb/tb_rx_word_aligner.sv
`timescale 1ns/1ps
module tb_rx_word_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] rx_word = '0;
  logic [19:0] word_out;
  logic        locked;
  int checks = 0, errors = 0;
  int e = 0, slip = 0;
  int gap = -1, b1lo = -1, b1hi = -1, b2lo = -1, b2hi = -1, data_from = 1 << 30;

  always #2 clk = ~clk;

  rx_word_aligner dut (.clk(clk), .rst_n(rst_n), .rx_word(rx_word),
                       .word_out(word_out), .locked(locked));

  // {slip[4:0], offset needed[4:0]}
  localparam logic [9:0] VEC [6] = '{
    {5'd0, 5'd0}, {5'd19, 5'd1}, {5'd10, 5'd10},
    {5'd13, 5'd7}, {5'd7, 5'd13}, {5'd1, 5'd19}
  };

  function automatic logic [19:0] tw(int n);
    logic [4:0] a, b;
    if ((n >= b1lo && n < b1hi) || (n >= b2lo && n < b2hi)) return '0;
    if (n >= data_from || n == gap) begin
      a = 5'(n * 3); b = 5'(n * 3 + 1);
      return {b, ~b, a, ~a};
    end
    return (n % 2 == 0) ? {10'h2AA, 10'h17C} : {10'h2AA, 10'h283};
  endfunction

  function automatic logic [19:0] rword(int m);
    logic [39:0] c;
    c = {tw(m + 1), tw(m)};
    return c[slip +: 20];
  endfunction

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d actual %h expected %h", req, e, act, exp);
    end
  endtask

  task automatic run_to(int target);
    while (e < target) begin
      @(posedge clk);
      e++;
      @(negedge clk);
      rx_word = rword(e);
    end
  endtask

  task automatic do_reset(int s);
    slip = s; gap = -1; b1lo = -1; b1hi = -1; b2lo = -1; b2hi = -1;
    data_from = 1 << 30;
    @(negedge clk);
    rst_n = 1'b0; rx_word = '0; e = 0;
    repeat (3) @(negedge clk);
    check("R8 locked in reset", 20'(locked), 20'd0);
    check("R8 word in reset", word_out, 20'd0);
    rx_word = rword(0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at edge %0d", e);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Table walk: R1 R2 R3 R4 R5
    foreach (VEC[i]) begin
      int s, k, lk, base;
      s = int'(VEC[i][9:5]);
      k = int'(VEC[i][4:0]);
      lk = (k == 0) ? 5 : 256 * k + 4;
      do_reset(s);
      run_to(lk - 1);
      check("R5 not yet locked", 20'(locked), 20'd0);
      run_to(lk);
      check("R3/R4/R5 locked on time", 20'(locked), 20'd1);
      data_from = e + 4;
      base = e + 8;
      for (int j = 1; j <= 4; j++) begin
        run_to(base + j);
        check("R1 aligned word", word_out, (s == 0) ? tw(e - 2) : tw(e - 1));
      end
      check("R3 still locked on data", 20'(locked), 20'd1);
    end

    // R4: a comma-free window restarts the hit count
    do_reset(0);
    gap = 3;
    run_to(8);
    check("R4 gap restarts count", 20'(locked), 20'd0);
    run_to(9);
    check("R4 lock after gap", 20'(locked), 20'd1);

    // R6: 7 bad, 1 good, 7 bad keeps lock; then 8 bad drops it
    do_reset(0);
    run_to(5);
    check("R5 lock k=0", 20'(locked), 20'd1);
    b1lo = 10; b1hi = 17; b2lo = 18; b2hi = 25;
    run_to(30);
    check("R6 good word resets error run", 20'(locked), 20'd1);
    b1lo = 40; b1hi = 48;
    run_to(48);
    check("R6 seven bad windows keep lock", 20'(locked), 20'd1);
    run_to(49);
    check("R6 eighth bad window drops lock", 20'(locked), 20'd0);
    // R7: relock at same offset after 4 comma windows
    run_to(52);
    check("R7 not relocked early", 20'(locked), 20'd0);
    run_to(53);
    check("R7 relock at same offset", 20'(locked), 20'd1);
    run_to(56);
    check("R7 word after relock", word_out, tw(e - 2));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule